// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single channel of a general-purpose timer. Software loads a start count, picks a prescale divisor and a mode, and sets the enable bit. The channel then counts down once every (prescale + 1) clocks. When the count runs out, the channel sets its own bit in a shared interrupt status register. In one-shot mode the channel then stops. In periodic mode it reloads the start count and keeps going. The interrupt line is the pending bit qualified by the channel's interrupt enable.

Access is through a simple register port: a one-cycle write strobe with an address and data, and a separate combinational read address. There are four word locations. Address 0 is control/status. Address 1 is the start count. Address 2 is the live remaining count and is read-only. Address 3 is the shared interrupt status word, in which this channel owns bit `CH_IDX`.

Top module: `tmr_channel`

## Requirements
- R1: After reset, control/status reads 0x00000005 (prescale 5, everything else clear), and the start count, the live count, the status word and `irq` are all 0.
- R2: Control/status bits [7:0] hold the prescale value P. While enabled, the live count drops by one every P+1 clocks. A channel started with count N raises its pending bit exactly N*(P+1) clocks after the enabling write, and not earlier.
- R3: Control/status bit 27 set means periodic mode. Bit 27 clear means one-shot mode, and in that mode expiry leaves the live count at 0 and clears both the enable bit and the active bit.
- R4: In periodic mode, expiry reloads the live count from the start count, and the channel keeps counting with the active bit still set.
- R5: Control/status bit 30 is the enable bit. Setting it sets the active bit (bit 25) and resumes counting from the held count. Clearing it clears the active bit and freezes the live count.
- R6: Clearing the enable bit while the live count is 0 takes the expiry actions, so the pending bit becomes set.
- R7: A write that changes the prescale value while counting keeps the current live count, and counting continues from it at the new rate.
- R8: Address 2 returns the live remaining count on every cycle.
- R9: In the status word (address 3), writing 1 to bit `CH_IDX` clears the channel's pending bit, and writing 0 leaves it unchanged. A new expiry in the same cycle wins over the clear.
- R10: `irq` is high exactly when the pending bit is set and control/status bit 29 (interrupt enable) is set.
- R11: Writing the start count (address 1) loads the live count with the new value at once.
- R12: The active bit 25 is read-only, so writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The main count-down path is tried with a table of prescale, start-count, mode and interrupt-enable combinations. These include a prescale of 0, so that a tick comes on every clock, and a start count of 1, where the first tick is also the expiry. The table tells apart an off-by-one in the prescaler period from one in the count length, because the pending bit must appear on one exact edge and the live count is checked at each tick edge. Mode entries separate the one-shot stop from the periodic reload. Directed sequences then cover a freeze and resume, a mid-run prescale change, a mid-run reload, disabling at zero, and the write-one-to-clear behaviour of the status word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int BIT_ACT  = 25;
  localparam int BIT_PER  = 27;
  localparam int BIT_IE   = 29;
  localparam int BIT_EN   = 30;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_INIT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;
  localparam logic [DATA_W-1:0] CTRL_RST = 32'h0000_0005;

  // Assemble the control/status read word from its fields.
  function automatic logic [DATA_W-1:0] pack_ctrl(input logic [DATA_W-1:0] psc_ext,
                                                  input logic en, input logic per,
                                                  input logic ie);
    logic [DATA_W-1:0] w;
    w = psc_ext;
    w[BIT_EN]  = en;
    w[BIT_ACT] = en;
    w[BIT_PER] = per;
    w[BIT_IE]  = ie;
    return w;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  assign tick = run && !restart && (phase_q >= psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      phase_q <= '0;
    else if (restart || !run || tick) phase_q <= '0;
    else                             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop_zero,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic expire_tick;

  assign expire_tick = tick && (cnt <= ONE);
  assign expire      = expire_tick || stop_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (expire) cnt <= periodic ? reload_val : '0;
    else if (tick)   cnt <= cnt - ONE;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PSC_W  = 8,
  parameter int CH_IDX = 0,
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [PSC_W-1:0] PSC_RST = CTRL_RST[PSC_W-1:0];

  logic             en_q, per_q, ie_q, pend_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic             ctrl_wr, init_wr, stat_wr;
  logic             tick, expire, stop_zero;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign init_wr   = wr_en && (wr_addr == A_INIT);
  assign stat_wr   = wr_en && (wr_addr == A_STAT);
  assign stop_zero = ctrl_wr && en_q && !wr_data[BIT_EN] && (cnt_q == '0);

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(ctrl_wr || init_wr),
    .psc(psc_q), .tick(tick)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(init_wr),
    .load_val(wr_data[CNT_W-1:0]), .stop_zero(stop_zero), .periodic(per_q),
    .reload_val(init_q), .cnt(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= PSC_RST;
      en_q  <= 1'b0;
      per_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      psc_q <= wr_data[PSC_W-1:0];
      en_q  <= wr_data[BIT_EN];
      per_q <= wr_data[BIT_PER];
      ie_q  <= wr_data[BIT_IE];
    end else if (expire && !per_q) begin
      en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       init_q <= '0;
    else if (init_wr) init_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pend_q <= 1'b0;
    else if (expire)                   pend_q <= 1'b1;
    else if (stat_wr && wr_data[CH_IDX]) pend_q <= 1'b0;
  end

  assign irq = pend_q && ie_q;

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = pack_ctrl(DATA_W'(psc_q), en_q, per_q, ie_q);
      A_INIT:  rd_data = DATA_W'(init_q);
      A_DATA:  rd_data = DATA_W'(cnt_q);
      default: rd_data = DATA_W'(STAT_W'(pend_q) << CH_IDX);
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_q,
  input logic             run,
  input logic             periodic,
  input logic             pend,
  input logic             init_wr,
  input logic             ctrl_wr
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt > CNT_W'(1) && !init_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !init_wr) |=> $stable(cnt));

  a_r3_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic && !ctrl_wr) |=> (!run && cnt == '0));

  a_r4_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic && !init_wr) |=> (cnt == $past(init_q)));

  a_r6_expire_pends: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire), .cnt(cnt_q),
  .init_q(init_q), .run(en_q), .periodic(per_q), .pend(pend_q),
  .init_wr(init_wr), .ctrl_wr(ctrl_wr)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] IE  = 32'h2000_0000;
  localparam logic [31:0] PER = 32'h0800_0000;
  localparam logic [31:0] ACT = 32'h0200_0000;

  // {ie, periodic, prescale[7:0], count[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b0, 8'd0, 8'd5},
    {1'b0, 1'b0, 8'd1, 8'd4},
    {1'b1, 1'b1, 8'd3, 8'd3},
    {1'b0, 1'b0, 8'd2, 8'd1},
    {1'b1, 1'b1, 8'd0, 8'd1},
    {1'b0, 1'b1, 8'd4, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit over = 1'b0;

  always #5 clk = ~clk;

  tmr_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    #2_000_000;
    if (!over) begin
      over = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h5);
    rd(2'd1, v); chk("R1 init", v, 0);
    rd(2'd2, v); chk("R1 data", v, 0);
    rd(2'd3, v); chk("R1 stat", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R12 active bit is read-only
    wr(2'd0, ACT);
    rd(2'd0, v); chk("R12 act ro", v, 0);

    // Table: R2 R3 R4 R8 R10
    foreach (VEC[i]) begin
      logic ie, per;
      int p, n, t;
      ie = VEC[i][17]; per = VEC[i][16];
      p = int'(VEC[i][15:8]); n = int'(VEC[i][7:0]);
      t = n * (p + 1);
      wr(2'd0, 32'h0);
      wr(2'd3, 32'h1);
      wr(2'd1, 32'(n));
      wr(2'd0, EN | (ie ? IE : 0) | (per ? PER : 0) | 32'(p));
      for (int k = 1; k <= t; k++) begin
        @(posedge clk); #1;
        rd(2'd3, v); chk($sformatf("R2 pend v%0d k%0d", i, k), v, (k == t) ? 1 : 0);
        if (k % (p + 1) == 0 && k < t) begin
          rd(2'd2, v); chk($sformatf("R8 live v%0d k%0d", i, k), v, 32'(n - k / (p + 1)));
        end
      end
      chk($sformatf("R10 irq v%0d", i), 32'(irq), 32'(ie));
      rd(2'd0, v);
      if (per) begin
        chk($sformatf("R4 act v%0d", i), v & (EN | ACT), EN | ACT);
        rd(2'd2, v); chk($sformatf("R4 reload v%0d", i), v, 32'(n));
      end else begin
        chk($sformatf("R3 stop v%0d", i), v & (EN | ACT), 0);
        rd(2'd2, v); chk($sformatf("R3 zero v%0d", i), v, 0);
      end
    end

    // R6 disable at zero counts as expiry; R9 write-1-to-clear; R10 gating
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1);
    wr(2'd1, 32'h0);
    wr(2'd0, EN | 32'd7);
    wr(2'd0, IE | 32'd7);
    rd(2'd3, v); chk("R6 pend", v, 1);
    chk("R10 irq on", 32'(irq), 1);
    wr(2'd0, 32'd7);
    chk("R10 irq gated", 32'(irq), 0);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R9 write0 keeps", v, 1);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R9 write1 clears", v, 0);

    // R5 freeze and resume
    wr(2'd1, 32'd5);
    wr(2'd0, EN);
    repeat (2) @(posedge clk);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R5 act clear", v & ACT, 0);
    repeat (5) @(posedge clk);
    #1;
    rd(2'd2, v); chk("R5 frozen", v, 3);
    rd(2'd3, v); chk("R5 no pend", v, 0);
    wr(2'd0, EN);
    rd(2'd0, v); chk("R5 act set", v & ACT, ACT);
    @(posedge clk); #1;
    rd(2'd2, v); chk("R5 resume", v, 2);

    // R7 prescale change keeps count
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd10);
    wr(2'd0, EN | 32'd3);
    repeat (8) @(posedge clk);
    wr(2'd0, EN);
    rd(2'd2, v); chk("R7 kept", v, 8);
    repeat (3) @(posedge clk);
    #1;
    rd(2'd2, v); chk("R7 new rate", v, 5);

    // R11 start-count write reloads live count
    wr(2'd1, 32'd20);
    rd(2'd2, v); chk("R11 load", v, 20);
    @(posedge clk); #1;
    rd(2'd2, v); chk("R11 continue", v, 19);

    over = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule